// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Receive Extractor

This block takes the signaling timeslot byte (timeslot 16) of each received E1 frame, one byte per strobe, and finds the 16-frame signaling multiframe. The start of a multiframe is marked by a zero pattern in the first four bits of that byte. Frame alignment and CRC-4 checking are done upstream.

Once the multiframe is found, the block splits every later signaling byte into two four-bit ABCD codes. Each code belongs to one voice timeslot, and the block stores it in a single per-timeslot table. The table has two read ports. The processor-side port returns the raw ABCD code for a chosen timeslot. The TDM-side port returns the byte to place in the same timeslot of the outgoing signaling stream. Both views are fed from every write, and no enable gates either of them.

The block also reports three things: whether the multiframe is locked, which frame number arrived last, and the remote multiframe alarm bit seen in the alignment frame. While the multiframe is not locked, nothing is written and the last good codes are held.

Top module: `cas_rx_extract`

## Requirements
- R1: After reset, `mf_locked`, `mf_phase` and `far_mf_alarm` are 0, and both read ports return 0 for every timeslot.
- R2: While searching, a byte whose upper nibble (`byte[7:4]`, bits 1-4 of the timeslot) is 0000 locks the multiframe only if the byte received just before it was not 0x00. One cycle after that byte, `mf_locked` is 1 and `mf_phase` is 0. A first-ever byte, or a byte that follows 0x00, never locks.
- R3: While locked, each received byte advances `mf_phase` by one, modulo 16. `mf_phase` always holds the frame number of the byte received last.
- R4: While locked, the byte of frame n (1 to 15) writes `byte[7:4]` as the ABCD code of timeslot n and `byte[3:0]` as the ABCD code of timeslot n+16. The byte of frame 0 writes nothing. A written code can be read one cycle after the strobe.
- R5: `tdm_byte` carries the stored ABCD code of `tdm_ts` in bits [7:4] and 0000 in bits [3:0]. For the same timeslot it always agrees with `cpu_abcd`.
- R6: Timeslots 0 and 16 carry no signaling and always read as 0 on both ports.
- R7: On a frame-0 byte with upper nibble 0000 (at lock or while locked), `far_mf_alarm` takes `byte[2]` (bit 6 of the timeslot). At all other times it holds its value.
- R8: While locked, a single frame-0 byte with a non-zero upper nibble keeps the lock. A correct frame 0 clears that miss. A second consecutive miss drops `mf_locked` to 0 with `mf_phase` 0, and the search resumes with the next byte.
- R9: While not locked, no stored ABCD code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts16_vld | input | 1 | Strobe: `ts16_byte` holds this frame's signaling byte |
| ts16_byte | input | 8 | Signaling timeslot byte; bit 7 is the first bit on the line |
| cpu_ts | input | 5 | Timeslot selected on the processor read port |
| cpu_abcd | output | 4 | Stored ABCD code of `cpu_ts` |
| tdm_ts | input | 5 | Timeslot currently going out on the TDM stream |
| tdm_byte | output | 8 | Outgoing signaling byte for `tdm_ts` |
| mf_locked | output | 1 | Multiframe locked |
| mf_phase | output | 4 | Frame number of the last byte received |
| far_mf_alarm | output | 1 | Remote multiframe alarm bit received |

## Verification
Every result is registered once, on the clock edge that samples the strobe. Lock, loss, phase, alarm and stored codes are therefore due exactly one cycle after the byte is presented.

The bench drives each byte for one cycle starting at a falling edge. It samples all outputs at the next falling edge, half a cycle after that single register stage. The read ports are combinational from the table, so the bench sweeps all 32 timeslots on both ports between strobes, after each multiframe. This covers both the writes that should have happened and the held values during loss of lock.

// File: rtl/cas_rx_pkg.sv
package cas_rx_pkg;
  localparam int unsigned FRAMES_PER_MF = 16;
  localparam int unsigned CODE_W        = 4;
  localparam int unsigned SIG_BYTE_W    = 8;
  localparam int unsigned ALARM_POS     = 2;
  localparam int unsigned MISS_LIMIT    = 2;

  typedef enum logic {
    MF_SEARCH = 1'b0,
    MF_LOCKED = 1'b1
  } mf_state_e;
endpackage

// File: rtl/cas_mf_align.sv
module cas_mf_align
  import cas_rx_pkg::*;
#(
  parameter int unsigned FRAMES = FRAMES_PER_MF,
  parameter int unsigned MISSES = MISS_LIMIT,
  localparam int unsigned PH_W  = $clog2(FRAMES),
  localparam int unsigned MS_W  = $clog2(MISSES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld,
  input  logic [SIG_BYTE_W-1:0] byte_in,
  output logic                  locked,
  output logic [PH_W-1:0]       phase,
  output logic                  alarm,
  output logic                  wr_en,
  output logic [PH_W-1:0]       wr_frame
);

  mf_state_e         st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [MS_W-1:0]   miss_q, miss_d;
  logic              al_q, al_d;
  logic              prevnz_q, prevnz_d;
  logic [PH_W-1:0]   idx;
  logic              mas_ok;

  assign mas_ok = (byte_in[SIG_BYTE_W-1 -: CODE_W] == '0);
  assign idx    = (ph_q == PH_W'(FRAMES - 1)) ? '0 : ph_q + 1'b1;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    miss_d   = miss_q;
    al_d     = al_q;
    prevnz_d = prevnz_q;
    if (vld) begin
      prevnz_d = |byte_in;
      unique case (st_q)
        MF_SEARCH: begin
          if (mas_ok && prevnz_q) begin
            st_d   = MF_LOCKED;
            ph_d   = '0;
            miss_d = '0;
            al_d   = byte_in[ALARM_POS];
          end
        end
        MF_LOCKED: begin
          ph_d = idx;
          if (idx == '0) begin
            if (mas_ok) begin
              miss_d = '0;
              al_d   = byte_in[ALARM_POS];
            end else if (32'(miss_q) + 32'd1 >= MISSES) begin
              st_d   = MF_SEARCH;
              ph_d   = '0;
              miss_d = '0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
        default: st_d = MF_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= MF_SEARCH;
      ph_q     <= '0;
      miss_q   <= '0;
      al_q     <= 1'b0;
      prevnz_q <= 1'b0;
    end else if (vld) begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      miss_q   <= miss_d;
      al_q     <= al_d;
      prevnz_q <= prevnz_d;
    end
  end

  assign locked   = (st_q == MF_LOCKED);
  assign phase    = ph_q;
  assign alarm    = al_q;
  assign wr_en    = locked && vld && (idx != '0);
  assign wr_frame = idx;

  // Lock is only taken on a byte carrying the zero alignment nibble
  assert_lock_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(vld) && $past(byte_in[SIG_BYTE_W-1 -: CODE_W]) == '0));

  // Phase steps by one inside a multiframe while locked
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && vld && phase != PH_W'(FRAMES - 1)) |=> (locked && phase == $past(phase) + 1'b1));

  // Lock can only be lost on a failed frame-0 byte
  assert_loss_at_f0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(vld) && $past(phase) == PH_W'(FRAMES - 1)
                       && $past(byte_in[SIG_BYTE_W-1 -: CODE_W]) != '0));

endmodule

// File: rtl/cas_sig_store.sv
module cas_sig_store
  import cas_rx_pkg::*;
#(
  parameter int unsigned FRAMES = FRAMES_PER_MF,
  localparam int unsigned NUM_TS = 2 * FRAMES,
  localparam int unsigned PH_W   = $clog2(FRAMES),
  localparam int unsigned TS_W   = $clog2(NUM_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PH_W-1:0]   wr_frame,
  input  logic [CODE_W-1:0] wr_hi,
  input  logic [CODE_W-1:0] wr_lo,
  input  logic [TS_W-1:0]   rd_a_idx,
  output logic [CODE_W-1:0] rd_a_data,
  input  logic [TS_W-1:0]   rd_b_idx,
  output logic [CODE_W-1:0] rd_b_data
);

  logic [CODE_W-1:0]        mem [NUM_TS];
  logic [NUM_TS*CODE_W-1:0] mem_flat;

  for (genvar g = 0; g < NUM_TS; g++) begin : g_slot
    localparam int unsigned FRM = g % FRAMES;
    if (FRM == 0) begin : g_none
      assign mem[g] = '0;
    end else begin : g_sig
      logic              en;
      logic [CODE_W-1:0] din;
      logic [CODE_W-1:0] q;
      assign en  = we && (wr_frame == PH_W'(FRM));
      assign din = (g < FRAMES) ? wr_hi : wr_lo;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= din;
      end
      assign mem[g] = q;
    end
    assign mem_flat[g*CODE_W +: CODE_W] = mem[g];
  end

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];

  // Table is frozen whenever no write is presented
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));

endmodule

// File: rtl/cas_rx_extract.sv
module cas_rx_extract
  import cas_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ts16_vld,
  input  logic [SIG_BYTE_W-1:0] ts16_byte,
  input  logic [4:0]            cpu_ts,
  output logic [CODE_W-1:0]     cpu_abcd,
  input  logic [4:0]            tdm_ts,
  output logic [SIG_BYTE_W-1:0] tdm_byte,
  output logic                  mf_locked,
  output logic [3:0]            mf_phase,
  output logic                  far_mf_alarm
);

  localparam int unsigned PH_W = $clog2(FRAMES_PER_MF);

  logic            rst_meta, rst_sync;
  logic            wr_en;
  logic [PH_W-1:0] wr_frame;
  logic [CODE_W-1:0] tdm_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cas_mf_align #(.FRAMES(FRAMES_PER_MF), .MISSES(MISS_LIMIT)) u_align (
    .clk      (clk),
    .rst_n    (rst_sync),
    .vld      (ts16_vld),
    .byte_in  (ts16_byte),
    .locked   (mf_locked),
    .phase    (mf_phase),
    .alarm    (far_mf_alarm),
    .wr_en    (wr_en),
    .wr_frame (wr_frame)
  );

  cas_sig_store #(.FRAMES(FRAMES_PER_MF)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync),
    .we        (wr_en),
    .wr_frame  (wr_frame),
    .wr_hi     (ts16_byte[SIG_BYTE_W-1 -: CODE_W]),
    .wr_lo     (ts16_byte[CODE_W-1:0]),
    .rd_a_idx  (cpu_ts),
    .rd_a_data (cpu_abcd),
    .rd_b_idx  (tdm_ts),
    .rd_b_data (tdm_code)
  );

  assign tdm_byte = {tdm_code, {(SIG_BYTE_W-CODE_W){1'b0}}};

  // Both destinations see the same stored code
  assert_ports_agree_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (cpu_ts == tdm_ts) |-> (tdm_byte[SIG_BYTE_W-1 -: CODE_W] == cpu_abcd));

endmodule

// File: tb/cas_rx_extract_test.sv
module cas_rx_extract_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ts16_vld;
  logic [7:0] ts16_byte;
  logic [4:0] cpu_ts, tdm_ts;
  logic [3:0] cpu_abcd;
  logic [7:0] tdm_byte;
  logic       mf_locked;
  logic [3:0] mf_phase;
  logic       far_mf_alarm;

  int tests = 0;
  int fails = 0;
  int exp_code [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_rx_extract uut (
    .clk(clk), .rst_n(rst_n), .ts16_vld(ts16_vld), .ts16_byte(ts16_byte),
    .cpu_ts(cpu_ts), .cpu_abcd(cpu_abcd), .tdm_ts(tdm_ts), .tdm_byte(tdm_byte),
    .mf_locked(mf_locked), .mf_phase(mf_phase), .far_mf_alarm(far_mf_alarm)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input int ts, input int k);
    return 4'((ts * 7 + k * 3 + 5) % 16);
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    ts16_vld  = 1'b1;
    ts16_byte = b;
    @(negedge clk);
    ts16_vld  = 1'b0;
    ts16_byte = 8'h5A;
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < 32; t++) begin
      cpu_ts = 5'(t);
      tdm_ts = 5'(t);
      #1;
      check({req, " cpu"}, int'(cpu_abcd), exp_code[t]);
      check({req, " tdm"}, int'(tdm_byte), exp_code[t] * 16);
    end
  endtask

  task automatic send_mf(input int k);
    for (int n = 1; n < 16; n++) begin
      send({code_of(n, k), code_of(n + 16, k)});
      check("R3 phase", int'(mf_phase), n);
      check("R3 locked", int'(mf_locked), 1);
      exp_code[n]      = int'(code_of(n, k));
      exp_code[n + 16] = int'(code_of(n + 16, k));
    end
    sweep("R4");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 32; t++) exp_code[t] = 0;
    rst_n = 1'b0; ts16_vld = 1'b0; ts16_byte = 8'h00; cpu_ts = '0; tdm_ts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 locked", int'(mf_locked), 0);
    check("R1 phase", int'(mf_phase), 0);
    check("R1 alarm", int'(far_mf_alarm), 0);
    sweep("R1");

    // R2 search: first byte, zero predecessor, non-aligned byte
    send(8'h0F); check("R2 first byte", int'(mf_locked), 0);
    send(8'h00); check("R2 after nz", int'(mf_locked), 1);
    // 0x0F then 0x00: 0x00 follows non-zero, so it locks; restart from reset
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
    check("R1 relreset", int'(mf_locked), 0);
    send(8'h00); check("R2 first zero", int'(mf_locked), 0);
    send(8'h0F); check("R2 zero pred", int'(mf_locked), 0);
    send(8'hA5); check("R2 no mas", int'(mf_locked), 0);
    send(8'h0F);
    check("R2 lock", int'(mf_locked), 1);
    check("R2 phase0", int'(mf_phase), 0);
    check("R7 alarm set", int'(far_mf_alarm), 1);
    sweep("R6 idle");

    send_mf(0);
    send(8'h0B);
    check("R7 alarm clr", int'(far_mf_alarm), 0);
    check("R3 wrap", int'(mf_phase), 0);
    sweep("R4 f0 no write");
    send_mf(1);

    // R8 single miss keeps lock; alarm held on miss
    send(8'h5F);
    check("R8 miss1 locked", int'(mf_locked), 1);
    check("R7 alarm held", int'(far_mf_alarm), 0);
    send_mf(2);
    send(8'h0B);   // good frame 0 clears miss
    send_mf(3);
    send(8'h7B);
    check("R8 cleared miss", int'(mf_locked), 1);
    send_mf(4);
    send(8'h3B);
    check("R8 lost", int'(mf_locked), 0);
    check("R8 phase", int'(mf_phase), 0);

    // R9 unlocked bytes change nothing
    for (int n = 1; n < 16; n++) begin
      send({4'hE, 4'(n)});
      check("R9 unlocked", int'(mf_locked), 0);
    end
    check("R9 alarm held", int'(far_mf_alarm), 0);
    sweep("R9");

    // Relock and resume extraction
    send(8'h0F);
    check("R2 relock", int'(mf_locked), 1);
    check("R7 relock alarm", int'(far_mf_alarm), 1);
    send_mf(5);
    check("R6 ts0", exp_code[0], 0);
    check("R6 ts16", exp_code[16], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule